// File: doc/BRIEF.md
# I2C Word-Register Slave

This block is the serial front end of a device whose registers are 16 bits wide. It watches an I2C bus through oversampled SCL and SDA inputs in the system clock domain. It drives the data line only through an open-drain pull-down enable. After a start condition it compares the first byte against a fixed 7-bit device address.

In a write transfer, the next two bytes set a register pointer. Only the low ten bits of that address are kept. Each following pair of bytes, high byte first, is written to a simple synchronous register-file port. In a read transfer, the block fetches the word at the pointer and shifts it out high byte first. It keeps supplying words as long as the master acknowledges. The pointer advances by one after every complete word and wraps within the 10-bit space.

A stop condition returns the block to idle and clears the pointer. To read from a nonzero address, a master therefore writes the register address, issues a repeated start and then reads.

Top module: `i2c_wordreg_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start and begins device-address reception. A rising SDA while SCL is high is a stop and returns the block to idle.
- R2: The first byte after a start is a 7-bit address, MSB first, then a direction bit (0 = master writes, 1 = master reads). When the address equals 0x2E, the slave pulls SDA low during the ninth clock.
- R3: When the address does not match, the slave never pulls SDA low, makes no register access, and ignores the bus until the next start or stop.
- R4: In a write transfer, the two bytes after the address byte form the register address, high byte first, and each byte is acknowledged. The pointer becomes {high[1:0], low[7:0]}, so high-byte bits 7..2 have no effect.
- R5: The following bytes are taken in pairs, high byte first, and each byte is acknowledged. After the low byte, reg_we pulses for one cycle with reg_addr set to the pointer and reg_wdata set to {high, low}.
- R6: sda_oe turns on or off only while the synchronized SCL is low. The only exception is release on a start or stop.
- R7: One cycle after a stop is detected, reg_addr is 0 and sda_oe is 0.
- R8: In a read transfer, a word is fetched with a one-cycle reg_re when the address byte is acknowledged and again at each word boundary. reg_rdata is sampled in the cycle after reg_re. The word is sent MSB first: bits 15..8, then the master's acknowledge, then bits 7..0.
- R9: The pointer increments by one after each complete word, whether written or read. It wraps from 0x3FF to 0x000.
- R10: A master non-acknowledge in a read makes the slave release SDA and wait for a start or stop. A non-acknowledge after the high byte leaves the pointer unchanged.
- R11: A repeated start in any state restarts device-address reception and keeps the pointer.
- R12: During and after reset, sda_oe, reg_we and reg_re are 0 and reg_addr is 0.
- R13: reg_we and reg_re are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | PTR_W (10) | Register pointer presented to the register file |
| reg_wdata | output | 16 | Word to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Word returned the cycle after reg_re |

## Verification
The hardest situation to reach from the ports is a master non-acknowledge after only the high byte of a read word. Checking it needs a second read of the same address, which shows that the pointer did not move. The stimulus writes a register address, issues a repeated start and reads one byte with a non-acknowledge. It then clocks a further byte to show that the line stays released, and re-enters read mode with another repeated start. A repeated start between the two register-address bytes is reached the same way, by cutting the write sequence short. Random bursts that start near 0x3FF with set don't-care bits cover the pointer wrap.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(BYTE_W + 1);
    localparam logic [6:0] DEFAULT_DEV_ADDR = 7'h2E;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGHI,
        ST_REGLO,
        ST_WDHI,
        ST_WDLO,
        ST_RDHI,
        ST_RDLO,
        ST_IGNORE
    } slot_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic slot_is_tx(slot_e s);
        return (s == ST_RDHI) || (s == ST_RDLO);
    endfunction

    function automatic logic slot_is_active(slot_e s);
        return (s != ST_IDLE) && (s != ST_IGNORE);
    endfunction

    function automatic logic addr_hit(logic [BYTE_W-1:0] b, logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events
    import i2cw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_lvl
);
    localparam int N_LINES = 2;
    localparam int L_SCL   = 0;
    localparam int L_SDA   = 1;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] synced;
    logic [N_LINES-1:0] prev;

    assign raw[L_SCL] = scl_i;
    assign raw[L_SDA] = sda_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .q   (synced[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    always_comb begin
        ev.scl_rise = !prev[L_SCL] &&  synced[L_SCL];
        ev.scl_fall =  prev[L_SCL] && !synced[L_SCL];
        ev.start    =  prev[L_SCL] &&  synced[L_SCL] &&  prev[L_SDA] && !synced[L_SDA];
        ev.stop     =  prev[L_SCL] &&  synced[L_SCL] && !prev[L_SDA] &&  synced[L_SDA];
        ev.sda      =  synced[L_SDA];
    end

    assign scl_lvl = synced[L_SCL];
endmodule

// File: rtl/i2cw_proto.sv
module i2cw_proto
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEFAULT_DEV_ADDR,
    parameter int         PTR_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [WORD_W-1:0] reg_rdata
);
    slot_e              slot;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  rx_sr;
    logic [BYTE_W-1:0]  hold_byte;
    logic [BYTE_W-2:0]  tx_rest;
    logic [WORD_W-1:0]  rd_word;
    logic               mack;
    logic               rd_cap;
    logic [PTR_W-1:0]   ptr;

    assign reg_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            hold_byte <= '0;
            tx_rest   <= '0;
            rd_word   <= '0;
            mack      <= 1'b0;
            rd_cap    <= 1'b0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            rd_cap <= reg_re;
            if (rd_cap) rd_word <= reg_rdata;
            if (reg_we) ptr <= ptr + 1'b1;

            if (ev.stop) begin
                slot    <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                ptr     <= '0;
            end else if (ev.start) begin
                slot    <= ST_DEVADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (slot_is_active(slot)) begin
                // sample on the rising clock edge
                if (ev.scl_rise) begin
                    if (bit_cnt < ACK_SLOT) rx_sr <= {rx_sr[BYTE_W-2:0], ev.sda};
                    else                    mack  <= !ev.sda;
                    if (bit_cnt < SLOT_END) bit_cnt <= bit_cnt + 1'b1;
                end
                // drive only after the falling clock edge
                if (ev.scl_fall) begin
                    if (bit_cnt == ACK_SLOT) begin
                        unique case (slot)
                            ST_DEVADDR: begin
                                if (addr_hit(rx_sr, DEV_ADDR)) begin
                                    sda_oe <= 1'b1;
                                    if (rx_sr[0]) reg_re <= 1'b1;
                                end else begin
                                    slot <= ST_IGNORE;
                                end
                            end
                            ST_REGHI, ST_WDHI: begin
                                hold_byte <= rx_sr;
                                sda_oe    <= 1'b1;
                            end
                            ST_REGLO: begin
                                ptr    <= PTR_W'({hold_byte, rx_sr});
                                sda_oe <= 1'b1;
                            end
                            ST_WDLO: begin
                                reg_wdata <= {hold_byte, rx_sr};
                                reg_we    <= 1'b1;
                                sda_oe    <= 1'b1;
                            end
                            ST_RDHI: sda_oe <= 1'b0;
                            ST_RDLO: begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                reg_re <= 1'b1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (bit_cnt == SLOT_END) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        unique case (slot)
                            ST_DEVADDR: begin
                                if (rx_sr[0]) begin
                                    slot    <= ST_RDHI;
                                    sda_oe  <= !rd_word[WORD_W-1];
                                    tx_rest <= rd_word[WORD_W-2:BYTE_W];
                                end else begin
                                    slot <= ST_REGHI;
                                end
                            end
                            ST_REGHI: slot <= ST_REGLO;
                            ST_REGLO: slot <= ST_WDHI;
                            ST_WDHI:  slot <= ST_WDLO;
                            ST_WDLO:  slot <= ST_WDHI;
                            ST_RDHI: begin
                                if (mack) begin
                                    slot    <= ST_RDLO;
                                    sda_oe  <= !rd_word[BYTE_W-1];
                                    tx_rest <= rd_word[BYTE_W-2:0];
                                end else begin
                                    slot <= ST_IGNORE;
                                end
                            end
                            ST_RDLO: begin
                                if (mack) begin
                                    slot    <= ST_RDHI;
                                    sda_oe  <= !rd_word[WORD_W-1];
                                    tx_rest <= rd_word[WORD_W-2:BYTE_W];
                                end else begin
                                    slot <= ST_IGNORE;
                                end
                            end
                            default: slot <= ST_IGNORE;
                        endcase
                    end else if (bit_cnt != '0 && slot_is_tx(slot)) begin
                        sda_oe  <= !tx_rest[BYTE_W-2];
                        tx_rest <= {tx_rest[BYTE_W-3:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_wordreg_slave.sv
module i2c_wordreg_slave
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = DEFAULT_DEV_ADDR,
    parameter int         PTR_W       = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [WORD_W-1:0] reg_rdata
);
    bus_ev_t bus_ev;
    logic    scl_s;

    i2cw_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev      (bus_ev),
        .scl_lvl (scl_s)
    );

    i2cw_proto #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (bus_ev),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             ev_start,
    input logic             ev_stop,
    input logic             sda_oe,
    input logic             reg_we,
    input logic             reg_re,
    input logic [PTR_W-1:0] reg_addr
);
    a_r6_pull_in_low_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_s));

    a_r6_release_in_low_phase: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> (!$past(scl_s) || $past(ev_start) || $past(ev_stop)));

    a_r11_start_releases: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> !sda_oe);

    a_r7_stop_clears_ptr: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (reg_addr == '0 && !sda_oe));

    a_r13_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    a_r13_we_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    a_r13_re_single: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    a_r9_step_after_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !ev_stop) |=> reg_addr == PTR_W'($past(reg_addr) + 1));
endmodule

bind i2c_wordreg_slave i2cw_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .ev_start (bus_ev.start),
    .ev_stop  (bus_ev.stop),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr)
);

// File: tb/i2c_wordreg_slave_tb.sv
`timescale 1ns/1ps
module i2c_wordreg_slave_tb;
    localparam int Q = 6;
    localparam int LIMIT = 190000;
    localparam logic [6:0] DEV = 7'h2E;
    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, reg_we, reg_re;
    logic [9:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata = '0;
    wire  sda_bus = m_sda & ~sda_oe;

    logic [15:0] rf      [DEPTH];
    logic [15:0] exp_mem [DEPTH];
    int n_checks = 0, n_fail = 0, we_count = 0;
    bit glitch = 0, done = 0;

    always #2 clk = ~clk;

    i2c_wordreg_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_re) reg_rdata <= rf[reg_addr];
        if (reg_we) begin
            rf[reg_addr] <= reg_wdata;
            we_count <= we_count + 1;
        end
    end

    function automatic logic [15:0] init_word(int i);
        return 16'(i * 40503) ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] mk_word(int salt, int k);
        return 16'(salt * 941 + k * 7919) ^ 16'hB00B;
    endfunction

    function automatic int wrap_idx(logic [15:0] a16, int k);
        return (int'(a16[9:0]) + k) % DEPTH;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wait_q(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1; m_scl = 1; wait_q(); m_sda = 0; wait_q(); m_scl = 0; wait_q();
    endtask

    task automatic bus_rstart();
        m_sda = 1; wait_q(); m_scl = 1; wait_q(); m_sda = 0; wait_q(); m_scl = 0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 0; wait_q(); m_scl = 1; wait_q(); m_sda = 1; wait_q();
    endtask

    task automatic write_bit(input logic b);
        m_sda = b; wait_q(); m_scl = 1; wait_q(); wait_q(); m_scl = 0; wait_q();
    endtask

    task automatic read_bit(output logic b);
        logic s1;
        m_sda = 1; wait_q(); m_scl = 1;
        @(negedge clk); s1 = sda_bus;
        repeat (Q - 1) @(negedge clk); b = sda_bus;
        if (b !== s1) glitch = 1;
        wait_q(); m_scl = 0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) write_bit(v[i]);
        read_bit(a);
        ack = (a == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            v[i] = b;
        end
        write_bit(!give_ack);
    endtask

    // R2 R4 R5 R9 R13: address, pointer set, burst of words
    task automatic wr_burst(input logic [15:0] a16, input int n, input int salt);
        bit ok = 1, ak;
        int we0 = we_count;
        logic [15:0] w;
        bus_start();
        send_byte({DEV, 1'b0}, ak); ok &= ak;
        send_byte(a16[15:8], ak); ok &= ak;
        send_byte(a16[7:0], ak); ok &= ak;
        for (int k = 0; k < n; k++) begin
            w = mk_word(salt, k);
            send_byte(w[15:8], ak); ok &= ak;
            send_byte(w[7:0], ak); ok &= ak;
            exp_mem[wrap_idx(a16, k)] = w;
        end
        bus_stop();
        chk(ok, "R2 R4 R5 write acks", 32'(ok), 32'd1);
        chk(we_count - we0 == n, "R13 one strobe per word", 32'(we_count - we0), 32'(n));
        for (int k = 0; k < n; k++)
            chk(rf[wrap_idx(a16, k)] === exp_mem[wrap_idx(a16, k)], "R5 R9 stored word",
                32'(rf[wrap_idx(a16, k)]), 32'(exp_mem[wrap_idx(a16, k)]));
        chk(reg_addr == 10'd0, "R7 pointer after stop", 32'(reg_addr), 32'd0);
    endtask

    // R8 R9 R11: combined format read
    task automatic rd_burst(input logic [15:0] a16, input int n);
        bit ok = 1, ak;
        logic [7:0] hi, lo;
        bus_start();
        send_byte({DEV, 1'b0}, ak); ok &= ak;
        send_byte(a16[15:8], ak); ok &= ak;
        send_byte(a16[7:0], ak); ok &= ak;
        bus_rstart();
        send_byte({DEV, 1'b1}, ak); ok &= ak;
        chk(ok, "R2 R11 read setup acks", 32'(ok), 32'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(1'b1, hi);
            recv_byte(k != n - 1, lo);
            chk({hi, lo} === exp_mem[wrap_idx(a16, k)], "R8 R9 read word",
                32'({hi, lo}), 32'(exp_mem[wrap_idx(a16, k)]));
        end
        bus_stop();
    endtask

    initial begin
        logic [7:0] hi, lo, v;
        logic [15:0] w;
        bit ak, ok;
        int we0;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < DEPTH; i++) begin
            rf[i] = init_word(i);
            exp_mem[i] = init_word(i);
        end
        repeat (5) @(negedge clk);
        chk(sda_oe == 0 && reg_we == 0 && reg_re == 0 && reg_addr == 0, "R12 reset state",
            {sda_oe, reg_we, reg_re, reg_addr}, 32'd0);
        rst = 0;
        repeat (4) @(negedge clk);
        chk(sda_oe == 0 && reg_we == 0 && reg_re == 0 && reg_addr == 0, "R12 after reset",
            {sda_oe, reg_we, reg_re, reg_addr}, 32'd0);

        // R3: wrong address, write direction
        we0 = we_count;
        ok = 1;
        bus_start();
        send_byte({7'h2F, 1'b0}, ak);
        chk(!ak, "R3 wrong address not acked", 32'(ak), 32'd0);
        send_byte(8'h00, ak); ok &= !ak;
        send_byte(8'h10, ak); ok &= !ak;
        send_byte(8'h12, ak); ok &= !ak;
        send_byte(8'h34, ak); ok &= !ak;
        bus_stop();
        chk(ok, "R3 later bytes ignored", 32'(ok), 32'd1);
        chk(we_count == we0, "R3 no write", 32'(we_count), 32'(we0));
        // R3: wrong address, read direction; slave stays silent
        bus_start();
        send_byte({7'h2C, 1'b1}, ak);
        recv_byte(1'b0, v);
        bus_stop();
        chk(v == 8'hFF && !ak, "R3 read to other address silent", {ak, v}, 32'h0FF);

        // R4: don't-care upper address bits
        wr_burst(16'hA855, 1, 3);
        rd_burst(16'h0055, 1);

        // R9: wrap from 0x3FF to 0 with don't-care bits set
        wr_burst(16'hFFFE, 3, 7);
        rd_burst(16'h03FE, 3);

        // R7 R1: stop clears pointer, read from address 0 without setup
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        recv_byte(1'b1, hi); recv_byte(1'b1, lo);
        chk({hi, lo} === exp_mem[0], "R7 read after stop from zero", 32'({hi, lo}), 32'(exp_mem[0]));
        recv_byte(1'b1, hi); recv_byte(1'b0, lo);
        chk({hi, lo} === exp_mem[1], "R9 read pointer step", 32'({hi, lo}), 32'(exp_mem[1]));
        bus_stop();

        // R10: nack after high byte, released line, pointer unchanged
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        send_byte(8'h01, ak);
        send_byte(8'h33, ak);
        bus_rstart();
        send_byte({DEV, 1'b1}, ak);
        recv_byte(1'b0, hi);
        chk(hi === exp_mem[16'h133][15:8], "R10 high byte before nack", 32'(hi), 32'(exp_mem[16'h133][15:8]));
        recv_byte(1'b0, v);
        chk(v == 8'hFF, "R10 line released after nack", 32'(v), 32'hFF);
        bus_rstart();
        send_byte({DEV, 1'b1}, ak);
        recv_byte(1'b1, hi); recv_byte(1'b0, lo);
        chk({hi, lo} === exp_mem[16'h133], "R10 pointer kept after nack", 32'({hi, lo}), 32'(exp_mem[16'h133]));
        bus_stop();

        // R11: repeated start between register address bytes
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        send_byte(8'h03, ak);
        bus_rstart();
        ok = 1;
        send_byte({DEV, 1'b0}, ak); ok &= ak;
        send_byte(8'h00, ak); ok &= ak;
        send_byte(8'h20, ak); ok &= ak;
        w = 16'hC3A5;
        send_byte(w[15:8], ak); ok &= ak;
        send_byte(w[7:0], ak); ok &= ak;
        bus_stop();
        exp_mem[16'h020] = w;
        chk(ok, "R11 restart acks", 32'(ok), 32'd1);
        chk(rf[16'h020] === w, "R11 write after restart", 32'(rf[16'h020]), 32'(w));
        chk(rf[16'h320] === exp_mem[16'h320], "R11 aborted address unused", 32'(rf[16'h320]), 32'(exp_mem[16'h320]));

        // random bursts
        for (int it = 0; it < 10; it++) begin
            logic [15:0] a16;
            int n;
            a16 = 16'($urandom);
            if (it % 4 == 0) a16[9:0] = 10'h3FE;
            n = 1 + int'($urandom % 3);
            wr_burst(a16, n, 100 + it);
            rd_burst(a16, n);
        end

        chk(!glitch, "R6 data stable while clock high", 32'(glitch), 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule